// File: doc/BRIEF.md
# Stereo Serial Audio Port

The port moves two-channel 16-bit audio between parallel sample words and a three-wire serial link made of a bit clock, a frame clock and a data line in each direction. Each frame has 64 bit periods. The frame clock is high for the left slot and low for the right slot. Each slot is 32 bits wide and holds one 16-bit two's complement sample. Two static select pins set the format, and the same format applies to both directions. One pin chooses whether the sample fills the front or the rear half of the slot. The other chooses whether the most or the least significant bit is sent first.

A mode pin decides where the link clocks come from. In master mode the port divides its system clock to make the bit and frame clocks, drives them out and raises a drive-enable output. In slave mode it takes both clocks from its inputs. In both modes the link clocks pass through synchronisers, and an edge detector on the synchronised bit clock finds the bit boundaries. A frame starts on the first falling bit-clock edge after the frame clock has risen. The mode pin may change while the port runs. The port realigns on the next frame start.

Top module: `stereo_sport`

## Requirements
- R1: With master_sel high, bclk_out toggles every DIV_HALF system clocks and clk_drive is high. lrclk_out changes only on falling bclk_out edges, and it is high for 32 bit periods and low for 32 in each 64-bit frame.
- R2: With master_sel low, clk_drive is low, bclk_out rests high and lrclk_out rests low. Framing follows bclk_in and lrclk_in.
- R3: Payload position within a slot, counting slot bit 0 as the first bit after the slot starts: with front_sel high the sample occupies slot bits 0..15, and with front_sel low it occupies slot bits 16..31.
- R4: With msb_sel high the first payload bit is sample bit 15 and the last is bit 0. With msb_sel low the order is reversed. Both directions use this order.
- R5: sdata_out is 0 during every slot bit outside the payload.
- R6: The value of sdata_in during slot bits outside the payload has no effect on rx_left or rx_right.
- R7: tx_left and tx_right are latched at each frame start. Changes made to them later in the frame appear only in the next frame.
- R8: After the rising bit clock of the last bit of the right slot, rx_valid pulses for exactly one cycle before the next bit period starts. At that pulse rx_left holds the left-slot sample and rx_right holds the right-slot sample of that frame.
- R9: While rst_n is low, sdata_out, rx_valid, rx_left and rx_right are 0, bclk_out is 1 and lrclk_out is 0.
- R10: After master_sel, front_sel or msb_sel changes at run time, the data in both directions is correct again from the third frame start that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | 1 | 1 = generate link clocks, 0 = receive them |
| front_sel | input | 1 | 1 = payload in front half of slot, 0 = rear half |
| msb_sel | input | 1 | 1 = MSB first, 0 = LSB first |
| bclk_in | input | 1 | Bit clock input (slave) |
| lrclk_in | input | 1 | Frame clock input (slave), high = left |
| sdata_in | input | 1 | Serial data from the link |
| tx_left | input | 16 | Left sample to send |
| tx_right | input | 16 | Right sample to send |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrclk_out | output | 1 | Generated frame clock (master) |
| clk_drive | output | 1 | Drive enable for the clock outputs |
| sdata_out | output | 1 | Serial data to the link |
| rx_left | output | 16 | Last received left sample |
| rx_right | output | 16 | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe: new received pair |

## Verification
Each bit clock edge takes two synchroniser cycles and one detect cycle to reach the core. Because of that, sdata_out settles about three system clocks after a falling bit clock. The bench samples it at the next rising edge, which comes DIV_HALF clocks after the fall. rx_valid follows the last rising edge by about four clocks. The bench therefore expects it while its own bit counter still reads 63, before the next falling edge. The bench changes the transmit words at bit 40, far from any frame start, so each frame's expected data is the word that was present at that frame's start. After each configuration change the bench skips two frames and then checks three frames exhaustively across all mode, placement and order settings.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // 1 when slot position pos carries payload
  function automatic logic in_payload(int pos, int slot_w, int data_w, logic front);
    if (front) return pos < data_w;
    return pos >= (slot_w - data_w);
  endfunction

  // sample bit index carried at slot position pos
  function automatic int payload_index(int pos, int slot_w, int data_w, logic front, logic msb);
    int k;
    k = front ? pos : pos - (slot_w - data_w);
    return msb ? (data_w - 1 - k) : k;
  endfunction

endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int DIV_HALF  = 6,
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic lrclk
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int CW = $clog2(FRAME_BITS);
  localparam int DW = $clog2(DIV_HALF + 1);

  logic [DW-1:0] div;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      cnt   <= '1;
      bclk  <= 1'b1;
      lrclk <= 1'b0;
    end else if (!en) begin
      div   <= '0;
      cnt   <= '1;
      bclk  <= 1'b1;
      lrclk <= 1'b0;
    end else if (div == DW'(DIV_HALF - 1)) begin
      div  <= '0;
      bclk <= ~bclk;
      if (bclk) begin
        cnt   <= cnt_nxt;
        lrclk <= (cnt_nxt < CW'(SLOT_BITS));
      end
    end else begin
      div <= div + DW'(1);
    end
  end
endmodule

// File: rtl/sport_framer.sv
module sport_framer #(
  parameter int SLOT_BITS = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bclk_s,
  input  logic                               lrclk_s,
  output logic                               fall_ev,
  output logic                               rise_ev,
  output logic                               frame_start,
  output logic                               locked,
  output logic [$clog2(2*SLOT_BITS)-1:0]     bit_idx
);
  localparam int CW = $clog2(2 * SLOT_BITS);

  logic bclk_q;
  logic lr_at_fall;

  assign fall_ev     = bclk_q & ~bclk_s;
  assign rise_ev     = ~bclk_q & bclk_s;
  assign frame_start = fall_ev & lrclk_s & ~lr_at_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q     <= 1'b1;
      lr_at_fall <= 1'b0;
      locked     <= 1'b0;
      bit_idx    <= '1;
    end else begin
      bclk_q <= bclk_s;
      if (fall_ev) begin
        lr_at_fall <= lrclk_s;
        if (frame_start) begin
          bit_idx <= '0;
          locked  <= 1'b1;
        end else begin
          bit_idx <= bit_idx + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int DATA_BITS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fall_ev,
  input  logic                           frame_start,
  input  logic                           locked,
  input  logic [$clog2(2*SLOT_BITS)-1:0] bit_idx,
  input  logic                           front,
  input  logic                           msb,
  input  logic [DATA_BITS-1:0]           tx_l,
  input  logic [DATA_BITS-1:0]           tx_r,
  output logic                           sdata
);
  localparam int CW = $clog2(2 * SLOT_BITS);

  logic [DATA_BITS-1:0] sh_l, sh_r, word, shifted;
  logic                 drive_q;
  logic                 nxt_bit;
  int                   pos, sel;

  always_comb begin
    pos     = int'(bit_idx[CW-2:0]);
    sel     = payload_index(pos, SLOT_BITS, DATA_BITS, front, msb);
    word    = bit_idx[CW-1] ? sh_r : sh_l;
    shifted = word >> sel;
    nxt_bit = locked && in_payload(pos, SLOT_BITS, DATA_BITS, front) && shifted[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l    <= '0;
      sh_r    <= '0;
      drive_q <= 1'b0;
      sdata   <= 1'b0;
    end else begin
      drive_q <= fall_ev;
      if (frame_start) begin
        sh_l <= tx_l;
        sh_r <= tx_r;
      end
      if (drive_q) sdata <= nxt_bit;
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int DATA_BITS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rise_ev,
  input  logic                           locked,
  input  logic [$clog2(2*SLOT_BITS)-1:0] bit_idx,
  input  logic                           front,
  input  logic                           msb,
  input  logic                           sdin_s,
  output logic [DATA_BITS-1:0]           rx_l,
  output logic [DATA_BITS-1:0]           rx_r,
  output logic                           rx_valid
);
  localparam int CW = $clog2(2 * SLOT_BITS);
  localparam logic [CW-1:0] LAST = CW'(2 * SLOT_BITS - 1);
  localparam logic [DATA_BITS-1:0] ONE = DATA_BITS'(1);

  logic [DATA_BITS-1:0] acc_l, acc_r, mask;
  logic                 take, done_q;
  int                   pos, sel;

  always_comb begin
    pos  = int'(bit_idx[CW-2:0]);
    sel  = payload_index(pos, SLOT_BITS, DATA_BITS, front, msb);
    mask = ONE << sel;
    take = rise_ev && locked && in_payload(pos, SLOT_BITS, DATA_BITS, front);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l    <= '0;
      acc_r    <= '0;
      done_q   <= 1'b0;
      rx_valid <= 1'b0;
      rx_l     <= '0;
      rx_r     <= '0;
    end else begin
      if (take) begin
        if (bit_idx[CW-1]) acc_r <= sdin_s ? (acc_r | mask) : (acc_r & ~mask);
        else               acc_l <= sdin_s ? (acc_l | mask) : (acc_l & ~mask);
      end
      done_q   <= rise_ev && locked && (bit_idx == LAST);
      rx_valid <= done_q;
      if (done_q) begin
        rx_l <= acc_l;
        rx_r <= acc_r;
      end
    end
  end
endmodule

// File: rtl/stereo_sport.sv
module stereo_sport #(
  parameter int DIV_HALF    = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_BITS   = 32,
  parameter int DATA_BITS   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_sel,
  input  logic                 front_sel,
  input  logic                 msb_sel,
  input  logic                 bclk_in,
  input  logic                 lrclk_in,
  input  logic                 sdata_in,
  input  logic [DATA_BITS-1:0] tx_left,
  input  logic [DATA_BITS-1:0] tx_right,
  output logic                 bclk_out,
  output logic                 lrclk_out,
  output logic                 clk_drive,
  output logic                 sdata_out,
  output logic [DATA_BITS-1:0] rx_left,
  output logic [DATA_BITS-1:0] rx_right,
  output logic                 rx_valid
);
  localparam int CW = $clog2(2 * SLOT_BITS);

  logic gen_bclk, gen_lrclk;
  logic src_bclk, src_lrclk;
  logic bclk_s, lrclk_s, sdin_s;
  logic fall_ev, rise_ev, frame_start, locked;
  logic [CW-1:0] bit_idx;

  sport_clkgen #(.DIV_HALF(DIV_HALF), .SLOT_BITS(SLOT_BITS)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(master_sel), .bclk(gen_bclk), .lrclk(gen_lrclk)
  );

  assign bclk_out  = gen_bclk;
  assign lrclk_out = gen_lrclk;
  assign clk_drive = master_sel;
  assign src_bclk  = master_sel ? gen_bclk  : bclk_in;
  assign src_lrclk = master_sel ? gen_lrclk : lrclk_in;

  sport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sb (
    .clk(clk), .rst_n(rst_n), .d(src_bclk), .q(bclk_s));
  sport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sl (
    .clk(clk), .rst_n(rst_n), .d(src_lrclk), .q(lrclk_s));
  sport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd (
    .clk(clk), .rst_n(rst_n), .d(sdata_in), .q(sdin_s));

  sport_framer #(.SLOT_BITS(SLOT_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s), .lrclk_s(lrclk_s),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .frame_start(frame_start),
    .locked(locked), .bit_idx(bit_idx)
  );

  sport_tx #(.SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .frame_start(frame_start),
    .locked(locked), .bit_idx(bit_idx), .front(front_sel), .msb(msb_sel),
    .tx_l(tx_left), .tx_r(tx_right), .sdata(sdata_out)
  );

  sport_rx #(.SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .locked(locked),
    .bit_idx(bit_idx), .front(front_sel), .msb(msb_sel), .sdin_s(sdin_s),
    .rx_l(rx_left), .rx_r(rx_right), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
  parameter int SLOT_BITS = 32,
  parameter int DATA_BITS = 16,
  parameter int CW        = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_sel,
  input logic          front_sel,
  input logic          bclk_out,
  input logic          sdata_out,
  input logic          rx_valid,
  input logic          rise_ev,
  input logic          frame_start,
  input logic          locked,
  input logic [CW-1:0] bit_idx
);
  logic       front_q;
  logic [7:0] cfg_age;
  int         pos;
  logic       pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_q <= 1'b0;
      cfg_age <= '0;
    end else begin
      front_q <= front_sel;
      if (front_sel != front_q) cfg_age <= '0;
      else if (cfg_age != 8'hFF) cfg_age <= cfg_age + 8'd1;
    end
  end

  always_comb begin
    pos = int'(bit_idx[CW-2:0]);
    pay = front_sel ? (pos < DATA_BITS) : (pos >= SLOT_BITS - DATA_BITS);
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  valid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bit_idx == CW'(2 * SLOT_BITS - 1)));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && locked && cfg_age == 8'hFF && !pay) |-> !sdata_out);

  // R7
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_idx == '0 && locked));

  // R2
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && $past(!master_sel)) |-> bclk_out);
endmodule

bind stereo_sport sport_chk #(.SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .front_sel(front_sel),
  .bclk_out(bclk_out), .sdata_out(sdata_out), .rx_valid(rx_valid),
  .rise_ev(rise_ev), .frame_start(frame_start), .locked(locked), .bit_idx(bit_idx)
);

// File: tb/sim_stereo_sport.sv
module sim_stereo_sport;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1, front_sel = 1'b1, msb_sel = 1'b1;
  logic tb_bclk = 1'b1, tb_lr = 1'b0, sdata_in = 1'b0;
  logic [15:0] tx_left = '0, tx_right = '0;
  logic bclk_out, lrclk_out, clk_drive, sdata_out, rx_valid;
  logic [15:0] rx_left, rx_right;

  int total = 0, bad = 0;
  int scnt = 0, sbit = 63, bit_n = 63, gf = 0, fcfg = 0;
  int since_fall = 0, lr_hi = 0, vcnt = 0, vgood = 0;
  logic prev_b = 1'b1, lr_at_fall = 1'b0, chk_on = 1'b0;
  logic [15:0] cur_l = '0, cur_r = '0, snd_l = '0, snd_r = '0;

  stereo_sport u0 (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .front_sel(front_sel),
    .msb_sel(msb_sel), .bclk_in(tb_bclk), .lrclk_in(tb_lr), .sdata_in(sdata_in),
    .tx_left(tx_left), .tx_right(tx_right), .bclk_out(bclk_out),
    .lrclk_out(lrclk_out), .clk_drive(clk_drive), .sdata_out(sdata_out),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int n, int ch);
    if (n % 5 == 0) return ch != 0 ? 16'h8000 : 16'h7FFF;
    return 16'((n * 40503 + ch * 12345 + 7) & 16'hFFFF);
  endfunction

  // expected serial bit at frame bit b for word pair (l,r); pad supplies the off-payload value
  function automatic logic ser_bit(int b, logic [15:0] l, logic [15:0] r, logic pad);
    int p, k, i;
    logic [15:0] w;
    w = (b >= 32) ? r : l;
    p = b % 32;
    if (front_sel ? (p >= 16) : (p < 16)) return pad;
    k = front_sel ? p : p - 16;
    i = msb_sel ? 15 - k : k;
    w = w >> i;
    return w[0];
  endfunction

  task automatic step();
    logic b, lr;
    @(negedge clk);
    since_fall++;
    if (!master_sel) begin
      scnt++;
      if (scnt == HALF) begin
        scnt = 0;
        tb_bclk = ~tb_bclk;
        if (!tb_bclk) begin
          sbit = (sbit + 1) % 64;
          tb_lr = (sbit < 32);
        end
      end
    end
    b  = master_sel ? bclk_out  : tb_bclk;
    lr = master_sel ? lrclk_out : tb_lr;
    if (prev_b && !b) begin
      if (chk_on && master_sel)
        check(since_fall == 2 * HALF, "R1 bit period", since_fall, 2 * HALF);
      since_fall = 0;
      if (lr && !lr_at_fall) begin
        if (chk_on) begin
          check(lr_hi == 32, "R1 left slot length", lr_hi, 32);
          check(vcnt == 1, "R8 one strobe per frame", vcnt, 1);
        end
        gf++; fcfg++;
        chk_on = (fcfg >= 3);
        bit_n = 0; lr_hi = 0; vcnt = 0;
        cur_l = tx_left; cur_r = tx_right;
        snd_l = pat(gf + 700, 0); snd_r = pat(gf + 700, 1);
      end else begin
        bit_n++;
      end
      lr_at_fall = lr;
      sdata_in = ser_bit(bit_n, snd_l, snd_r, 1'b1);
      if (bit_n == 40) begin
        tx_left = pat(gf + 1, 0);
        tx_right = pat(gf + 1, 1);
      end
    end
    if (!prev_b && b && chk_on) begin
      if (lr) lr_hi++;
      check(sdata_out == ser_bit(bit_n, cur_l, cur_r, 1'b0),
            "R3,R4,R5,R7 tx bit", int'(sdata_out), int'(ser_bit(bit_n, cur_l, cur_r, 1'b0)));
      check(clk_drive == master_sel, "R1,R2 clk_drive", int'(clk_drive), int'(master_sel));
      if (!master_sel)
        check(bclk_out && !lrclk_out, "R2 idle clock outputs", int'({bclk_out, lrclk_out}), 2);
    end
    if (rx_valid && chk_on) begin
      vcnt++;
      check(bit_n == 63, "R8 strobe timing", bit_n, 63);
      check(rx_left == snd_l, "R3,R4,R6,R8 rx_left", int'(rx_left), int'(snd_l));
      check(rx_right == snd_r, "R3,R4,R6,R8 rx_right", int'(rx_right), int'(snd_r));
      if (rx_left == snd_l && rx_right == snd_r) vgood++;
    end
    prev_b = b;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) step();
    // R9 reset state
    check(sdata_out == 1'b0 && rx_valid == 1'b0, "R9 reset serial/strobe",
          int'({sdata_out, rx_valid}), 0);
    check(rx_left == 16'h0 && rx_right == 16'h0, "R9 reset words",
          int'({rx_left, rx_right}), 0);
    check(bclk_out && !lrclk_out, "R9 reset clocks", int'({bclk_out, lrclk_out}), 2);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 9; c++) begin
      master_sel = (c < 4) || (c == 8);
      front_sel  = (c == 8) ? 1'b0 : c[1];
      msb_sel    = (c == 8) ? 1'b1 : c[0];
      fcfg = 0; chk_on = 1'b0; vgood = 0;
      while (fcfg < 6) step();
      // R10 data recovers after a run-time configuration change
      check(vgood == 3, "R10 pairs after config change", vgood, 3);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule